// File: doc/BRIEF.md
# Configurable Logic Cell with Registered Outputs

This block is a single programmable logic cell. It holds two 16-entry truth tables, each addressed by a 4-bit input vector, and produces two one-bit results. In its default arrangement the two tables act as independent 4-input functions. A mode flag joins them into one 5-input function. In that mode a fifth input picks which table answers, and the joined result drives both outputs. Each output has its own flag that chooses between the combinational lookup result and a copy of it held in a flip-flop.

The whole configuration can be replaced on any rising clock edge through a load port: both truth tables and every mode flag are written in one cycle. With the memory flag set, a second and narrower write port changes a single bit of either table at run time. The tables then serve as two 16x1 RAMs. A read goes through the normal lookup path and needs no clock. A typical use places a 2-bit magnitude comparator in the cell, with "greater than" on one output and "equal" on the other.

Top module: `logic_cell`

## Requirements
- R1: In dual mode (`cfg_five`=0) `y_f` equals bit `in_f` of table F and `y_g` equals bit `in_g` of table G. Each input vector is read as an unsigned index, MSB first, and the two outputs do not affect each other.
- R2: In 5-input mode (`cfg_five`=1) both tables are indexed by `in_f`. With `in_e`=0 table F answers, and with `in_e`=1 table G answers. Both outputs carry that same result, and `in_g` has no effect.
- R3: When an output's register flag is 1, that output shows the lookup result from the inputs present before the last rising edge and holds it until the next edge. When the flag is 0, the output follows its inputs with no clock.
- R4: A synchronous reset clears both output registers, both tables and all mode flags. Every output then reads 0, and the reset wins over a configuration load in the same cycle.
- R5: With `cfg_we`=1, a rising edge loads `cfg_tbl_f`, `cfg_tbl_g` and the four mode flags together. Bit i of each table vector is the result for index i. A load is accepted at any time after reset.
- R6: With the memory flag set and `mem_we`=1, a rising edge writes `mem_din` into bit `mem_addr` of one table: F when `mem_tbl`=0, G when `mem_tbl`=1. The new bit appears on the combinational lookup path right after that edge.
- R7: With the memory flag clear, `mem_we` changes no table bit.
- R8: When `cfg_we` and an enabled `mem_we` arrive in the same cycle, the configuration load decides the table contents and the single-bit write is dropped.
- R9: The cell holds a 2-bit magnitude comparator. Let AB = `in[3:2]` and CD = `in[1:0]`. "AB > CD" is placed in F and "AB == CD" in G, and both are correct for all 16 input values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load the full configuration |
| cfg_tbl_f | input | 16 | Truth table F contents |
| cfg_tbl_g | input | 16 | Truth table G contents |
| cfg_five | input | 1 | Mode flag: join the tables into one 5-input function |
| cfg_reg_f | input | 1 | Mode flag: register `y_f` |
| cfg_reg_g | input | 1 | Mode flag: register `y_g` |
| cfg_mem | input | 1 | Mode flag: allow run-time single-bit writes |
| in_f | input | 4 | Index into table F, and into both tables in 5-input mode |
| in_g | input | 4 | Index into table G in dual mode |
| in_e | input | 1 | Table select in 5-input mode |
| mem_we | input | 1 | Single-bit write enable |
| mem_tbl | input | 1 | Write target: 0 = F, 1 = G |
| mem_addr | input | 4 | Bit index of the write |
| mem_din | input | 1 | Bit value to write |
| y_f | output | 1 | First result |
| y_g | output | 1 | Second result |

## Verification
A wrong table bit appears at the output only when the matching index is applied, so every table bit is read back under several modes. A stale or mis-steered table select in 5-input mode makes the two outputs disagree, or gives the wrong half of a 32-row function, on the very input that exercises it. A register-path fault shows one cycle late or one cycle early, so registered checks sample both just before and just after the edge. A misrouted write changes the other table or the wrong address, and the full read-back of both tables finds it.

// File: rtl/logic_cell.sv
module logic_cell #(
  parameter int K = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [(1<<K)-1:0] cfg_tbl_f,
  input  logic [(1<<K)-1:0] cfg_tbl_g,
  input  logic              cfg_five,
  input  logic              cfg_reg_f,
  input  logic              cfg_reg_g,
  input  logic              cfg_mem,
  input  logic [K-1:0]      in_f,
  input  logic [K-1:0]      in_g,
  input  logic              in_e,
  input  logic              mem_we,
  input  logic              mem_tbl,
  input  logic [K-1:0]      mem_addr,
  input  logic              mem_din,
  output logic              y_f,
  output logic              y_g
);
  localparam int DEPTH = 1 << K;

  logic [DEPTH-1:0] tbl_f, tbl_g;
  logic mode_five, mode_reg_f, mode_reg_g, mode_mem;
  logic q_f, q_g;

  wire mem_wr = mem_we && mode_mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_f      <= '0;
      tbl_g      <= '0;
      mode_five  <= 1'b0;
      mode_reg_f <= 1'b0;
      mode_reg_g <= 1'b0;
      mode_mem   <= 1'b0;
    end else if (cfg_we) begin
      tbl_f      <= cfg_tbl_f;
      tbl_g      <= cfg_tbl_g;
      mode_five  <= cfg_five;
      mode_reg_f <= cfg_reg_f;
      mode_reg_g <= cfg_reg_g;
      mode_mem   <= cfg_mem;
    end else if (mem_wr) begin
      if (mem_tbl) tbl_g[mem_addr] <= mem_din;
      else         tbl_f[mem_addr] <= mem_din;
    end
  end

  wire look_f  = tbl_f[in_f];
  wire look_g  = tbl_g[in_g];
  wire look_gf = tbl_g[in_f];

  wire wide   = in_e ? look_gf : look_f;
  wire comb_f = mode_five ? wide : look_f;
  wire comb_g = mode_five ? wide : look_g;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_f <= 1'b0;
      q_g <= 1'b0;
    end else begin
      q_f <= comb_f;
      q_g <= comb_g;
    end
  end

  assign y_f = mode_reg_f ? q_f : comb_f;
  assign y_g = mode_reg_g ? q_g : comb_g;

  // R2
  five_match_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_five && !mode_reg_f && !mode_reg_g) |-> (y_f == y_g));

  // R4
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (y_f == 1'b0 && y_g == 1'b0));

  // R5
  cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_we && !rst) |-> (tbl_f == $past(cfg_tbl_f) && tbl_g == $past(cfg_tbl_g)));

  // R6
  mem_write_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mem_we && mode_mem && !cfg_we && !rst)
      |-> ($past(mem_tbl) ? tbl_g[$past(mem_addr)] : tbl_f[$past(mem_addr)]) == $past(mem_din));

  // R7
  mem_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!cfg_we && !mode_mem && !rst) |-> ($stable(tbl_f) && $stable(tbl_g)));
endmodule

// File: tb/logic_cell_test.sv
module logic_cell_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_tbl_f = '0, cfg_tbl_g = '0;
  logic cfg_five = 1'b0, cfg_reg_f = 1'b0, cfg_reg_g = 1'b0, cfg_mem = 1'b0;
  logic [3:0] in_f = '0, in_g = '0;
  logic in_e = 1'b0;
  logic mem_we = 1'b0, mem_tbl = 1'b0, mem_din = 1'b0;
  logic [3:0] mem_addr = '0;
  logic y_f, y_g;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  logic_cell uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tbl_f(cfg_tbl_f), .cfg_tbl_g(cfg_tbl_g),
    .cfg_five(cfg_five), .cfg_reg_f(cfg_reg_f), .cfg_reg_g(cfg_reg_g), .cfg_mem(cfg_mem),
    .in_f(in_f), .in_g(in_g), .in_e(in_e), .mem_we(mem_we), .mem_tbl(mem_tbl),
    .mem_addr(mem_addr), .mem_din(mem_din), .y_f(y_f), .y_g(y_g)
  );

  function automatic bit gt(int i); return (i / 4) > (i % 4); endfunction
  function automatic bit eq(int i); return (i / 4) == (i % 4); endfunction
  function automatic bit fn5(int j); return (j % 3) == 0; endfunction
  function automatic bit pat_f(int a); return ((a * 7) % 5) < 2; endfunction
  function automatic bit pat_g(int a); return (a % 4) == 1 || a == 14; endfunction

  function automatic logic [15:0] build(int kind, int half);
    logic [15:0] v;
    for (int i = 0; i < 16; i++)
      case (kind)
        0: v[i] = gt(i);
        1: v[i] = eq(i);
        2: v[i] = fn5(half * 16 + i);
        3: v[i] = pat_f(i);
        default: v[i] = pat_g(i);
      endcase
    return v;
  endfunction

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic load(logic [15:0] tf, logic [15:0] tg, bit five, bit rf, bit rg, bit mem);
    @(negedge clk);
    cfg_tbl_f = tf; cfg_tbl_g = tg; cfg_five = five;
    cfg_reg_f = rf; cfg_reg_g = rg; cfg_mem = mem; cfg_we = 1'b1;
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic mem_write(bit tsel, int a, bit d);
    @(negedge clk);
    mem_tbl = tsel; mem_addr = 4'(a); mem_din = d; mem_we = 1'b1;
    @(posedge clk); #2;
    mem_we = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R4: a load during reset loses to the reset
    cfg_tbl_f = '1; cfg_tbl_g = '1; cfg_we = 1'b1;
    repeat (3) @(posedge clk);
    #2; cfg_we = 1'b0;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 16; i += 5) begin
      @(negedge clk); in_f = 4'(i); in_g = 4'(15 - i); #4;
      check(y_f, 1'b0, "R4 reset y_f");
      check(y_g, 1'b0, "R4 reset y_g");
    end

    // R1 R9 R5: comparator, combinational
    load(build(0, 0), build(1, 0), 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); in_f = 4'(i); in_g = 4'(i); #4;
      check(y_f, gt(i), "R9 gt");
      check(y_g, eq(i), "R9 eq");
    end
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); in_f = 4'(i); in_g = 4'(15 - i); #4;
      check(y_f, gt(i), "R1 independent f");
      check(y_g, eq(15 - i), "R1 independent g");
    end

    // R3: both registered, sampled before and after each edge
    load(build(0, 0), build(1, 0), 0, 1, 1, 0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); in_f = 4'(i); in_g = 4'((i * 5) % 16); #4;
      if (i > 0) begin
        check(y_f, gt(i - 1), "R3 hold f");
        check(y_g, eq(((i - 1) * 5) % 16), "R3 hold g");
      end
      @(posedge clk); #2;
      check(y_f, gt(i), "R3 reg f");
      check(y_g, eq((i * 5) % 16), "R3 reg g");
    end

    // R3: mixed, f registered, g bypassed
    load(build(0, 0), build(1, 0), 0, 1, 0, 0);
    for (int i = 0; i < 16; i += 3) begin
      @(negedge clk); in_f = 4'(i); in_g = 4'(i); #4;
      check(y_g, eq(i), "R3 bypass g");
      @(posedge clk); #2;
      check(y_f, gt(i), "R3 reg f mixed");
    end

    // R2: 5-input function, combinational
    load(build(2, 0), build(2, 1), 1, 0, 0, 0);
    for (int j = 0; j < 32; j++) begin
      @(negedge clk); in_e = j[4]; in_f = 4'(j); in_g = ~4'(j); #4;
      check(y_f, fn5(j), "R2 five f");
      check(y_g, fn5(j), "R2 five g");
    end
    // R2 R3: 5-input function, registered
    load(build(2, 0), build(2, 1), 1, 1, 1, 0);
    for (int j = 0; j < 32; j += 3) begin
      @(negedge clk); in_e = j[4]; in_f = 4'(j); in_g = 4'(j); #4;
      @(posedge clk); #2;
      check(y_f, fn5(j), "R2 five reg f");
      check(y_g, fn5(j), "R2 five reg g");
    end

    // R4: reset in operation clears registers and tables
    @(negedge clk); rst = 1'b1; in_e = 1'b0; in_f = 4'd0;
    @(posedge clk); #2;
    check(y_f, 1'b0, "R4 mid reset f");
    check(y_g, 1'b0, "R4 mid reset g");
    @(negedge clk); rst = 1'b0; #4;
    check(y_f, 1'b0, "R4 table cleared f");

    // R6: run-time writes, read on the lookup path
    load(16'h0000, 16'h0000, 0, 0, 0, 1);
    in_e = 1'b0;
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); in_f = 4'(a); in_g = 4'(a);
      mem_write(0, a, pat_f(a));
      check(y_f, pat_f(a), "R6 write f immediate");
      mem_write(1, a, pat_g(a));
      check(y_g, pat_g(a), "R6 write g immediate");
    end
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); in_f = 4'(a); in_g = 4'(15 - a); #4;
      check(y_f, pat_f(a), "R6 readback f");
      check(y_g, pat_g(15 - a), "R6 readback g");
    end

    // R7: writes ignored with the memory flag clear
    load(build(3, 0), build(4, 0), 0, 0, 0, 0);
    for (int a = 0; a < 16; a++) begin
      mem_write(a % 2 == 1, a, ~((a % 2 == 1) ? pat_g(a) : pat_f(a)));
      @(negedge clk); in_f = 4'(a); in_g = 4'(a); #4;
      check(y_f, pat_f(a), "R7 ignored f");
      check(y_g, pat_g(a), "R7 ignored g");
    end

    // R8: load and write in the same cycle
    load(16'h0000, 16'h0000, 0, 0, 0, 1);
    @(negedge clk);
    cfg_tbl_f = 16'h0000; cfg_tbl_g = 16'h0000; cfg_mem = 1'b1; cfg_we = 1'b1;
    mem_tbl = 1'b0; mem_addr = 4'd5; mem_din = 1'b1; mem_we = 1'b1;
    @(posedge clk); #2;
    cfg_we = 1'b0; mem_we = 1'b0;
    @(negedge clk); in_f = 4'd5; #4;
    check(y_f, 1'b0, "R8 load wins");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule